// File: doc/BRIEF.md
# Scanline Interrupt Counter

This block raises an interrupt request toward the CPU once a programmed number of visible video lines have been drawn. Software writes a count through a small set of fixed control addresses, arms the counter, and then receives a level interrupt when the count runs out. Line timing comes from outside the block: a one-cycle strobe per line, a flag that is high while the current line is inside the visible region, and a flag that is high while background or sprite drawing is switched on.

Inside are an 8-bit down-counter, an 8-bit reload latch, an enable flag and the interrupt register. A line counts only when all three line inputs agree. A line that finds the counter at zero ends the run. It raises the interrupt if the block was enabled, and it clears both the latch and the enable whether or not an interrupt was raised. When a count of N is loaded and armed, the interrupt is raised on the (N+1)th counted line.

Top module: `line_irq_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the counter, latch, enable and `irq_out` are all cleared to zero, and `irq_out` reads 0 after that edge.
- R2: A write (`wr_en` high) to address 0xC002 clears the enable flag and drops `irq_out` at that clock edge.
- R3: A write to 0xC003 or to 0xC004 while the enable flag is clear sets the enable flag and copies the latch into the counter.
- R4: A write to 0xC003 or 0xC004 while the enable flag is already set changes nothing.
- R5: A write to 0xC005 loads `wr_data` into the counter and into the latch at the same edge.
- R6: A line counts only in a cycle where `line_tick`, `line_visible` and `render_on` are all high. In any other cycle the counter is left as it is.
- R7: A counted line that finds a nonzero counter decrements it by one, so a value of 255 needs 255 counted lines to reach zero.
- R8: A counted line that finds the counter at zero sets `irq_out` if the enable flag is set. In either case it clears both the latch and the enable flag.
- R9: Once set, `irq_out` stays high through further lines and through arm or load writes until a write to 0xC002 or a reset.
- R10: When a write to one of the addresses 0xC002 to 0xC005 falls in the same cycle as a counted line, the write takes effect and that line is dropped.
- R11: Writes to any other 16-bit address, and cycles with `wr_en` low, have no effect on the counter, latch, enable or interrupt. All four addresses are compared in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| line_tick | input | 1 | One-cycle strobe at each video line |
| line_visible | input | 1 | High while the current line is in the visible region |
| render_on | input | 1 | High while background or sprite drawing is enabled |
| irq_out | output | 1 | Registered level interrupt request |

## Verification
The assertions assume that each input is a plain synchronous level sampled once per rising edge. They also assume that a write lasts exactly the one cycle in which `wr_en` is high, and that `line_tick` marks a line in a single cycle, so that one line cannot be counted twice. The stimulus changes every input only on the falling edge and gives each write and each line strobe one cycle. It places a write and a line strobe in the same cycle only on purpose, in the priority cases. The counter's value is observed only through the cycle in which `irq_out` rises, so every count is checked by how many counted lines pass before the interrupt.

// File: rtl/lic_pkg.sv
package lic_pkg;

  // Decoded CPU control action for one cycle
  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_DISARM = 2'd1,
    CMD_ARM    = 2'd2,
    CMD_LOAD   = 2'd3
  } lic_cmd_e;

endpackage

// File: rtl/lic_decode.sv
module lic_decode
  import lic_pkg::*;
#(
  parameter int              ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] ADDR_DISARM = 16'hC002,
  parameter logic [ADDR_W-1:0] ADDR_ARM_A  = 16'hC003,
  parameter logic [ADDR_W-1:0] ADDR_ARM_B  = 16'hC004,
  parameter logic [ADDR_W-1:0] ADDR_LOAD   = 16'hC005
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output lic_cmd_e          cmd
);

  // Full-width compare: aliases elsewhere in the space must not hit
  always_comb begin
    cmd = CMD_NONE;
    if (wr_en) begin
      if (wr_addr == ADDR_DISARM) begin
        cmd = CMD_DISARM;
      end else if (wr_addr == ADDR_ARM_A || wr_addr == ADDR_ARM_B) begin
        cmd = CMD_ARM;
      end else if (wr_addr == ADDR_LOAD) begin
        cmd = CMD_LOAD;
      end
    end
  end

endmodule

// File: rtl/lic_line_gate.sv
module lic_line_gate (
  input  logic line_tick,
  input  logic line_visible,
  input  logic render_on,
  output logic line_ev
);

  // A line counts only when it is visible and drawing is on
  assign line_ev = line_tick & line_visible & render_on;

endmodule

// File: rtl/lic_counter.sv
module lic_counter
  import lic_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  lic_cmd_e          cmd,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              line_ev,
  output logic [DATA_W-1:0] cnt_q,
  output logic [DATA_W-1:0] latch_q,
  output logic              en_q,
  output logic              fire
);

  localparam logic [DATA_W-1:0] ZERO = '0;
  localparam logic [DATA_W-1:0] ONE  = {{(DATA_W-1){1'b0}}, 1'b1};

  logic cnt_zero;
  logic line_taken;

  assign cnt_zero   = (cnt_q == ZERO);
  // A decoded write owns the cycle; the line is dropped
  assign line_taken = line_ev && (cmd == CMD_NONE);
  assign fire       = line_taken && cnt_zero && en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= ZERO;
      latch_q <= ZERO;
      en_q    <= 1'b0;
    end else begin
      case (cmd)
        CMD_DISARM: begin
          en_q <= 1'b0;
        end
        CMD_ARM: begin
          if (!en_q) begin
            en_q  <= 1'b1;
            cnt_q <= latch_q;
          end
        end
        CMD_LOAD: begin
          cnt_q   <= wr_data;
          latch_q <= wr_data;
        end
        default: begin
          if (line_taken) begin
            if (!cnt_zero) begin
              cnt_q <= cnt_q - ONE;
            end else begin
              latch_q <= ZERO;
              en_q    <= 1'b0;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/lic_irq_reg.sv
module lic_irq_reg
  import lic_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  lic_cmd_e cmd,
  input  logic     fire,
  output logic     irq_q
);

  // Level request: only the disarm write or reset takes it down
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else if (cmd == CMD_DISARM) begin
      irq_q <= 1'b0;
    end else if (fire) begin
      irq_q <= 1'b1;
    end
  end

endmodule

// File: rtl/line_irq_counter.sv
module line_irq_counter
  import lic_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter int                DATA_W      = 8,
  parameter logic [ADDR_W-1:0] ADDR_DISARM = 16'hC002,
  parameter logic [ADDR_W-1:0] ADDR_ARM_A  = 16'hC003,
  parameter logic [ADDR_W-1:0] ADDR_ARM_B  = 16'hC004,
  parameter logic [ADDR_W-1:0] ADDR_LOAD   = 16'hC005
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              line_tick,
  input  logic              line_visible,
  input  logic              render_on,
  output logic              irq_out
);

  lic_cmd_e          cmd;
  logic              line_ev;
  logic              fire;
  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] latch_q;
  logic              en_q;

  lic_decode #(
    .ADDR_W      (ADDR_W),
    .ADDR_DISARM (ADDR_DISARM),
    .ADDR_ARM_A  (ADDR_ARM_A),
    .ADDR_ARM_B  (ADDR_ARM_B),
    .ADDR_LOAD   (ADDR_LOAD)
  ) u_decode (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .cmd     (cmd)
  );

  lic_line_gate u_gate (
    .line_tick    (line_tick),
    .line_visible (line_visible),
    .render_on    (render_on),
    .line_ev      (line_ev)
  );

  lic_counter #(
    .DATA_W (DATA_W)
  ) u_counter (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd),
    .wr_data (wr_data),
    .line_ev (line_ev),
    .cnt_q   (cnt_q),
    .latch_q (latch_q),
    .en_q    (en_q),
    .fire    (fire)
  );

  lic_irq_reg u_irq (
    .clk   (clk),
    .rst   (rst),
    .cmd   (cmd),
    .fire  (fire),
    .irq_q (irq_out)
  );

endmodule

// File: rtl/lic_checker.sv
module lic_checker #(
  parameter int                ADDR_W      = 16,
  parameter int                DATA_W      = 8,
  parameter logic [ADDR_W-1:0] ADDR_DISARM = 16'hC002,
  parameter logic [ADDR_W-1:0] ADDR_ARM_A  = 16'hC003,
  parameter logic [ADDR_W-1:0] ADDR_ARM_B  = 16'hC004,
  parameter logic [ADDR_W-1:0] ADDR_LOAD   = 16'hC005
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              line_tick,
  input logic              line_visible,
  input logic              render_on,
  input logic              irq_out,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] latch_q,
  input logic              en_q
);

  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic w_dis, w_arm, w_load, w_any, counted;
  assign w_dis   = wr_en && (wr_addr == ADDR_DISARM);
  assign w_arm   = wr_en && (wr_addr == ADDR_ARM_A || wr_addr == ADDR_ARM_B);
  assign w_load  = wr_en && (wr_addr == ADDR_LOAD);
  assign w_any   = w_dis || w_arm || w_load;
  assign counted = line_tick && line_visible && render_on;

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (cnt_q == '0 && latch_q == '0 && !en_q && !irq_out));

  // R2
  a_r2_disarm: assert property (@(posedge clk) disable iff (rst)
    w_dis |=> (!en_q && !irq_out));

  // R3
  a_r3_arm_reload: assert property (@(posedge clk) disable iff (rst)
    (w_arm && !en_q) |=> (en_q && cnt_q == $past(latch_q)));

  // R4
  a_r4_arm_ignored: assert property (@(posedge clk) disable iff (rst)
    (w_arm && en_q) |=> (en_q && $stable(cnt_q) && $stable(latch_q)));

  // R5
  a_r5_load_both: assert property (@(posedge clk) disable iff (rst)
    w_load |=> (cnt_q == $past(wr_data) && latch_q == $past(wr_data)));

  // R6
  a_r6_no_count_idle: assert property (@(posedge clk) disable iff (rst)
    (!w_any && !counted) |=> ($stable(cnt_q) && $stable(latch_q) && $stable(en_q)));

  // R7
  a_r7_decrement: assert property (@(posedge clk) disable iff (rst)
    (!w_any && counted && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

  // R8
  a_r8_expire: assert property (@(posedge clk) disable iff (rst)
    (!w_any && counted && cnt_q == '0) |=>
      (!en_q && latch_q == '0 && (irq_out == ($past(en_q) || $past(irq_out)))));

  // R9
  a_r9_irq_held: assert property (@(posedge clk) disable iff (rst)
    (irq_out && !w_dis) |=> irq_out);

  // R10
  a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
    (w_load && counted) |=> (cnt_q == $past(wr_data)));

  // R11
  a_r11_quiet_irq: assert property (@(posedge clk) disable iff (rst)
    (!w_any && !counted) |=> (irq_out == $past(irq_out)));

endmodule

bind line_irq_counter lic_checker #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .ADDR_DISARM (ADDR_DISARM),
  .ADDR_ARM_A  (ADDR_ARM_A),
  .ADDR_ARM_B  (ADDR_ARM_B),
  .ADDR_LOAD   (ADDR_LOAD)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .line_tick    (line_tick),
  .line_visible (line_visible),
  .render_on    (render_on),
  .irq_out      (irq_out),
  .cnt_q        (cnt_q),
  .latch_q      (latch_q),
  .en_q         (en_q)
);

// File: tb/sim_line_irq_counter.sv
`timescale 1ns/1ps
module sim_line_irq_counter;

  localparam logic [15:0] A_DIS  = 16'hC002;
  localparam logic [15:0] A_ARM3 = 16'hC003;
  localparam logic [15:0] A_ARM4 = 16'hC004;
  localparam logic [15:0] A_LOAD = 16'hC005;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        line_tick = 1'b0;
  logic        line_visible = 1'b0;
  logic        render_on = 1'b0;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit    exp;
    string tag;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  line_irq_counter u0 (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .line_tick    (line_tick),
    .line_visible (line_visible),
    .render_on    (render_on),
    .irq_out      (irq_out)
  );

  // Driver: one cycle of stimulus plus the irq level expected after the edge
  task automatic cyc(input bit r, input bit we, input logic [15:0] a,
                     input logic [7:0] d, input bit t, input bit v, input bit e,
                     input bit exp, input string tag);
    item_t it;
    @(negedge clk);
    rst = r; wr_en = we; wr_addr = a; wr_data = d;
    line_tick = t; line_visible = v; render_on = e;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input bit exp, input string tag);
    cyc(1'b0, 1'b1, a, d, 1'b0, 1'b1, 1'b1, exp, tag);
  endtask

  task automatic line(input bit exp, input string tag);
    cyc(1'b0, 1'b0, 16'h0000, 8'h00, 1'b1, 1'b1, 1'b1, exp, tag);
  endtask

  task automatic idle(input bit exp, input string tag);
    cyc(1'b0, 1'b0, 16'h0000, 8'h00, 1'b0, 1'b1, 1'b1, exp, tag);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Monitor: compare a quarter period after each rising edge
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        checks++;
        if (irq_out !== it.exp) begin
          errors++;
          $display("FAIL %s: irq_out=%0b expected %0b", it.tag, irq_out, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) cyc(1'b1, 1'b0, 16'h0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R1 reset");
    line(1'b0, "R1 zero count disabled no irq");
    line(1'b0, "R8 disabled expiry no irq");

    // R5 R3 R7 R8: count of 3 fires on the 4th counted line
    wr(A_LOAD, 8'd3, 1'b0, "R5 load 3");
    wr(A_ARM3, 8'd0, 1'b0, "R3 arm");
    for (int i = 0; i < 3; i++) line(1'b0, "R7 decrement");
    line(1'b1, "R8 expire raises irq");
    // R9: held
    for (int i = 0; i < 3; i++) idle(1'b1, "R9 irq held idle");
    line(1'b1, "R9 irq held on line");
    wr(A_ARM4, 8'd0, 1'b1, "R9 irq held through arm");
    wr(A_DIS, 8'd0, 1'b0, "R2 disarm drops irq");
    // R8: latch cleared by expiry, re-arm gives zero count
    wr(A_ARM3, 8'd0, 1'b0, "R3 arm after expiry");
    line(1'b1, "R8 latch was cleared");
    wr(A_DIS, 8'd0, 1'b0, "R2 disarm");

    // R2: disarm stops the run
    wr(A_LOAD, 8'd1, 1'b0, "R5 load 1");
    wr(A_ARM3, 8'd0, 1'b0, "R3 arm");
    wr(A_DIS, 8'd0, 1'b0, "R2 disarm");
    line(1'b0, "R2 disabled count");
    line(1'b0, "R2 disabled no irq");

    // R4: arm while enabled is ignored
    wr(A_LOAD, 8'd2, 1'b0, "R5 load 2");
    wr(A_ARM4, 8'd0, 1'b0, "R3 arm");
    line(1'b0, "R7 2 to 1");
    wr(A_ARM3, 8'd0, 1'b0, "R4 arm while enabled");
    line(1'b0, "R4 1 to 0 no reload");
    line(1'b1, "R4 fires without reload");
    wr(A_DIS, 8'd0, 1'b0, "R2 disarm");

    // R6: gating
    wr(A_LOAD, 8'd1, 1'b0, "R5 load 1");
    wr(A_ARM3, 8'd0, 1'b0, "R3 arm");
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 16'h0, 8'h0, 1'b1, 1'b0, 1'b1, 1'b0, "R6 line not visible");
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 16'h0, 8'h0, 1'b1, 1'b1, 1'b0, 1'b0, "R6 render off");
    for (int i = 0; i < 3; i++) idle(1'b0, "R6 no strobe");
    line(1'b0, "R6 first counted line");
    line(1'b1, "R6 second counted line fires");
    wr(A_DIS, 8'd0, 1'b0, "R2 disarm");

    // R8: expiry while disabled clears latch silently
    wr(A_LOAD, 8'd1, 1'b0, "R5 load 1 disabled");
    line(1'b0, "R7 1 to 0 disabled");
    line(1'b0, "R8 disabled expiry silent");
    wr(A_ARM3, 8'd0, 1'b0, "R3 arm");
    line(1'b1, "R8 latch cleared while disabled");
    wr(A_DIS, 8'd0, 1'b0, "R2 disarm");

    // R10: write beats a coincident line
    wr(A_LOAD, 8'd1, 1'b0, "R5 load 1");
    wr(A_ARM3, 8'd0, 1'b0, "R3 arm");
    cyc(1'b0, 1'b1, A_LOAD, 8'd2, 1'b1, 1'b1, 1'b1, 1'b0, "R10 load with line");
    line(1'b0, "R10 2 to 1");
    line(1'b0, "R10 1 to 0");
    line(1'b1, "R10 fires after dropped line");
    wr(A_DIS, 8'd0, 1'b0, "R2 disarm");
    wr(A_LOAD, 8'd0, 1'b0, "R5 load 0");
    wr(A_ARM4, 8'd0, 1'b0, "R3 arm at zero");
    cyc(1'b0, 1'b1, A_DIS, 8'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R10 disarm with line no irq");
    line(1'b0, "R10 stays quiet");

    // R11: unrelated addresses and idle strobe
    wr(A_LOAD, 8'd2, 1'b0, "R5 load 2");
    wr(A_ARM3, 8'd0, 1'b0, "R3 arm");
    wr(16'hD005, 8'd0, 1'b0, "R11 alias address");
    wr(16'hC006, 8'd0, 1'b0, "R11 other address");
    cyc(1'b0, 1'b0, A_LOAD, 8'd0, 1'b0, 1'b1, 1'b1, 1'b0, "R11 wr_en low");
    cyc(1'b0, 1'b0, A_DIS, 8'd0, 1'b0, 1'b1, 1'b1, 1'b0, "R11 wr_en low disarm");
    line(1'b0, "R11 2 to 1");
    line(1'b0, "R11 1 to 0");
    line(1'b1, "R11 fires on count");
    wr(16'h4002, 8'd0, 1'b1, "R11 other address keeps irq");
    wr(A_DIS, 8'd0, 1'b0, "R2 disarm");

    // R7 boundary: 255
    wr(A_LOAD, 8'hFF, 1'b0, "R5 load 255");
    wr(A_ARM3, 8'd0, 1'b0, "R3 arm");
    for (int i = 0; i < 255; i++) line(1'b0, "R7 long count");
    line(1'b1, "R7 fires on line 256");
    wr(A_DIS, 8'd0, 1'b0, "R2 disarm");

    // R1: reset mid-run clears irq and latch
    wr(A_LOAD, 8'd0, 1'b0, "R5 load 0");
    wr(A_ARM3, 8'd0, 1'b0, "R3 arm");
    line(1'b1, "R8 immediate expiry");
    wr(A_LOAD, 8'd5, 1'b1, "R9 irq held through load");
    repeat (2) cyc(1'b1, 1'b0, 16'h0, 8'h0, 1'b0, 1'b0, 1'b0, 1'b0, "R1 reset drops irq");
    wr(A_ARM4, 8'd0, 1'b0, "R1 arm after reset");
    line(1'b1, "R1 latch zero after reset");

    idle(1'b1, "R9 final hold");
    @(negedge clk);
    repeat (3) @(posedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule